// File: doc/BRIEF.md
# Byte-Lane Parity Guard with First-Failure Capture

This block guards a 32-bit external memory with one even-parity bit per byte lane. On the write side it computes the four parity bits that go into storage alongside the data word. On the read side it compares each returned byte with its stored parity bit. When a byte fails, it records which lane failed and which of the two banks was being read.

Only the first failure is kept. Later failures are ignored until software turns checking off and then on again. Turning checking off also wipes the record. Software polls the status outputs, because the block raises no interrupt. A separate routing control can copy the captured error flag onto an upstream error line. Reads from on-chip memory, which carries no parity, are never checked.

The enable bit cannot be read back. Its power-up value is treated as unknown, so reset forces checking off.

Top module: `mem_byte_parity_guard`

## Requirements
- R1: `wr_par[i]` is the XOR of `wr_data[8*i+7:8*i]` for each lane i (0 to 3). The nine bits of a lane therefore hold an even number of ones.
- R2: A read is checked when checking is enabled, `rd_strobe` is high and `rd_local` is low. If any lane of that read has an odd number of ones across its byte and parity bit, `err_flag` is high after the next clock edge.
- R3: The captured lane index (`err_lane`, 0 to 3) and the `rd_bank` value of the failing read appear on the status outputs together with the flag.
- R4: When several lanes fail in one read, the lowest-numbered failing lane is recorded.
- R5: Once an error is held, later failing reads change neither the flag, the lane nor the bank.
- R6: Writing enable = 0 (`en_wr` high, `en_val` low) turns checking off. It also clears the record, so all status outputs read 0 after that edge.
- R7: Writing enable = 1 while checking is already on leaves a held error in place. Re-arming needs a disable write followed by an enable write.
- R8: Reads with `rd_local` high are never checked.
- R9: While checking is off, failing reads capture nothing and `err_flag`, `err_lane` and `err_bank` read 0.
- R10: Bytes presented with `rd_strobe` low are never checked.
- R11: `up_err` equals `err_flag` while `route_up` is high and is 0 while it is low.
- R12: While `rst_n` is low at a clock edge, checking is turned off and the record is cleared.
- R13: A read in the same cycle as an enable write is judged against the enable state held before that write. A disable write in that cycle leaves the record clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_data | input | 32 | Word being written to external memory |
| wr_par | output | 4 | Parity bits to store with `wr_data`, one per lane |
| rd_strobe | input | 1 | A read word is present this cycle |
| rd_local | input | 1 | The read targets on-chip memory and is not checked |
| rd_bank | input | 1 | Bank being read |
| rd_data | input | 32 | Word read back from memory |
| rd_par | input | 4 | Stored parity bits returned with `rd_data` |
| en_wr | input | 1 | Write strobe for the enable bit |
| en_val | input | 1 | Value written to the enable bit |
| route_up | input | 1 | Copy the error flag to `up_err` |
| err_flag | output | 1 | An error has been captured since the last re-arm |
| err_lane | output | 2 | Lane of the captured error |
| err_bank | output | 1 | Bank of the captured error |
| up_err | output | 1 | Error flag routed upstream |

## Verification
The assertions check several behaviours on every cycle:
- a held record stays fixed until a disable write;
- a disable write empties the status outputs;
- a qualifying failure is captured;
- local reads and the disabled state never raise the flag;
- the lane pick is one-hot and is the lowest failing lane;
- the upstream line stays low while routing is off.

Some behaviours only the bench scenarios can show: the lane and bank values actually recorded, that the write-side parity bits are correct, the re-arm order, and how a read resolves when an enable write lands in the same cycle.

// File: rtl/mbp_pkg.sv
// Package: shared definitions for the byte-lane parity guard.
// Assumes: the enable bit is written through a strobe plus a value.
package mbp_pkg;

    // Command decoded from one write to the enable bit
    typedef enum logic [1:0] {
        CMD_IDLE    = 2'b00,
        CMD_ENABLE  = 2'b01,
        CMD_DISABLE = 2'b10
    } en_cmd_e;

    // Turn the write strobe and the written value into a command
    function automatic en_cmd_e decode_cmd(input logic wr, input logic val);
        if (!wr)
            return CMD_IDLE;
        else if (val)
            return CMD_ENABLE;
        else
            return CMD_DISABLE;
    endfunction

endpackage

// File: rtl/mbp_lane_parity.sv
// Module: per-lane even-parity generation (write side) and mismatch
// detection (read side).
// Assumes: the data width is a whole number of lanes.
module mbp_lane_parity #(
    parameter int LANE_W = 8,
    parameter int LANES  = 4,
    localparam int DATA_W = LANE_W * LANES
) (
    input  logic [DATA_W-1:0] wr_data,
    output logic [LANES-1:0]  wr_par,
    input  logic [DATA_W-1:0] rd_data,
    input  logic [LANES-1:0]  rd_par,
    output logic [LANES-1:0]  mismatch
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        // Parity bit that makes the nine stored bits even
        assign wr_par[g]   = ^wr_data[g*LANE_W +: LANE_W];
        // Odd count across read byte plus stored bit means a failure
        assign mismatch[g] = (^rd_data[g*LANE_W +: LANE_W]) ^ rd_par[g];
    end

endmodule

// File: rtl/mbp_first_fail.sv
// Module: priority picker returning the lowest-numbered failing lane.
// Assumes: fail bits are combinational and valid in the same cycle.
module mbp_first_fail #(
    parameter int LANES = 4,
    localparam int IDX_W = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic [LANES-1:0] fail,
    output logic             any_fail,
    output logic [IDX_W-1:0] first_idx
);

    logic [LANES-1:0] pick_oh;

    // Scan from the top lane down so that the lowest failing lane wins
    always_comb begin
        any_fail  = |fail;
        first_idx = '0;
        pick_oh   = '0;
        for (int i = LANES - 1; i >= 0; i--) begin
            if (fail[i]) begin
                first_idx  = IDX_W'(i);
                pick_oh    = '0;
                pick_oh[i] = 1'b1;
            end
        end
    end

    // Check that exactly one lane is picked and no lower lane also failed
    always_comb begin
        // R4
        pick_onehot_chk: assert ($onehot0(pick_oh));
        // R4
        pick_lowest_chk: assert (((pick_oh - 1'b1) & fail & {LANES{any_fail}}) == '0);
    end

endmodule

// File: rtl/mbp_err_latch.sv
// Module: write-only enable bit and sticky first-error record.
// Assumes: synchronous active-low reset; reset forces checking off
// because the enable bit has no defined power-up value.
module mbp_err_latch #(
    parameter int IDX_W  = 2,
    parameter int BANK_W = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_wr,
    input  logic              en_val,
    input  logic              fail_seen,
    input  logic [IDX_W-1:0]  fail_idx,
    input  logic [BANK_W-1:0] fail_bank,
    output logic              err_flag_o,
    output logic [IDX_W-1:0]  err_lane_o,
    output logic [BANK_W-1:0] err_bank_o
);
    import mbp_pkg::*;

    en_cmd_e           cmd;
    logic              en_q;
    logic              lat_q;
    logic [IDX_W-1:0]  lane_q;
    logic [BANK_W-1:0] bank_q;

    // Decode the enable write this cycle
    assign cmd = decode_cmd(en_wr, en_val);

    // Hold the enable bit; only an explicit write changes it
    always_ff @(posedge clk) begin
        if (!rst_n)
            en_q <= 1'b0;
        else if (cmd != CMD_IDLE)
            en_q <= (cmd == CMD_ENABLE);
    end

    // Capture the first failure; a disable write clears the record
    always_ff @(posedge clk) begin
        if (!rst_n || cmd == CMD_DISABLE) begin
            lat_q  <= 1'b0;
            lane_q <= '0;
            bank_q <= '0;
        end else if (en_q && fail_seen && !lat_q) begin
            lat_q  <= 1'b1;
            lane_q <= fail_idx;
            bank_q <= fail_bank;
        end
    end

    // Status is forced inactive while checking is off
    assign err_flag_o = en_q & lat_q;
    assign err_lane_o = en_q ? lane_q : '0;
    assign err_bank_o = en_q ? bank_q : '0;

    // R5
    hold_record_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lat_q && cmd != CMD_DISABLE |=> lat_q && $stable(lane_q) && $stable(bank_q));
    // R6
    disable_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd == CMD_DISABLE |=> !err_flag_o && err_lane_o == '0 && err_bank_o == '0);
    // R2
    capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en_q && fail_seen && !lat_q && cmd != CMD_DISABLE |=> err_flag_o);
    // R9
    off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |-> !err_flag_o && err_lane_o == '0 && err_bank_o == '0);

endmodule

// File: rtl/mem_byte_parity_guard.sv
// Module: top of the byte-lane parity guard for external memory.
// Generates write parity, checks qualifying reads, keeps the first
// failure (lane and bank), and can route the flag upstream.
// Assumes: rd_* inputs are valid in the cycle rd_strobe is high.
module mem_byte_parity_guard #(
    parameter int LANE_W    = 8,
    parameter int LANES     = 4,
    parameter int NUM_BANKS = 2,
    localparam int DATA_W = LANE_W * LANES,
    localparam int IDX_W  = (LANES > 1) ? $clog2(LANES) : 1,
    localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] wr_data,
    output logic [LANES-1:0]  wr_par,
    input  logic              rd_strobe,
    input  logic              rd_local,
    input  logic [BANK_W-1:0] rd_bank,
    input  logic [DATA_W-1:0] rd_data,
    input  logic [LANES-1:0]  rd_par,
    input  logic              en_wr,
    input  logic              en_val,
    input  logic              route_up,
    output logic              err_flag,
    output logic [IDX_W-1:0]  err_lane,
    output logic [BANK_W-1:0] err_bank,
    output logic              up_err
);

    logic [LANES-1:0] mismatch;
    logic             any_fail;
    logic [IDX_W-1:0] first_idx;
    logic             fail_seen;

    mbp_lane_parity #(.LANE_W(LANE_W), .LANES(LANES)) u_parity (
        .wr_data (wr_data),
        .wr_par  (wr_par),
        .rd_data (rd_data),
        .rd_par  (rd_par),
        .mismatch(mismatch)
    );

    mbp_first_fail #(.LANES(LANES)) u_pick (
        .fail     (mismatch),
        .any_fail (any_fail),
        .first_idx(first_idx)
    );

    // Only strobed reads of external memory can report a failure
    assign fail_seen = rd_strobe & ~rd_local & any_fail;

    mbp_err_latch #(.IDX_W(IDX_W), .BANK_W(BANK_W)) u_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_wr     (en_wr),
        .en_val    (en_val),
        .fail_seen (fail_seen),
        .fail_idx  (first_idx),
        .fail_bank (rd_bank),
        .err_flag_o(err_flag),
        .err_lane_o(err_lane),
        .err_bank_o(err_bank)
    );

    // Route the flag to the upstream error line when allowed
    assign up_err = route_up & err_flag;

    // R8
    local_read_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_strobe && rd_local && !err_flag |=> !err_flag);
    // R10
    no_strobe_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_strobe && !err_flag |=> !err_flag);
    // R11
    route_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !route_up |-> !up_err);

endmodule

// File: tb/mem_byte_parity_guard_tb_top.sv
// Bench: behavioural reference model compared on every clock, plus
// scenario checks per requirement.
module mem_byte_parity_guard_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] wr_data;
    logic [3:0]  wr_par;
    logic        rd_strobe, rd_local;
    logic [0:0]  rd_bank;
    logic [31:0] rd_data;
    logic [3:0]  rd_par;
    logic        en_wr, en_val, route_up;
    logic        err_flag;
    logic [1:0]  err_lane;
    logic [0:0]  err_bank;
    logic        up_err;

    int total = 0;
    int bad = 0;
    bit finished = 0;
    int m_en = 0, m_lat = 0, m_lane = 0, m_bank = 0;
    int capture_log[$];

    always #10 clk = ~clk;

    mem_byte_parity_guard dut_i (
        .clk(clk), .rst_n(rst_n), .wr_data(wr_data), .wr_par(wr_par),
        .rd_strobe(rd_strobe), .rd_local(rd_local), .rd_bank(rd_bank),
        .rd_data(rd_data), .rd_par(rd_par), .en_wr(en_wr), .en_val(en_val),
        .route_up(route_up), .err_flag(err_flag), .err_lane(err_lane),
        .err_bank(err_bank), .up_err(up_err)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Even parity bits computed by counting ones
    function automatic logic [3:0] good_par(input logic [31:0] d);
        logic [3:0] p;
        for (int l = 0; l < 4; l++) begin
            int ones = 0;
            for (int b = 0; b < 8; b++) ones += d[l*8+b];
            p[l] = (ones % 2 == 1);
        end
        return p;
    endfunction

    // Lowest failing lane, or -1 when all lanes are clean
    function automatic int lowest_fail(input logic [31:0] d, input logic [3:0] p);
        logic [3:0] g = good_par(d);
        for (int l = 0; l < 4; l++)
            if (g[l] != p[l]) return l;
        return -1;
    endfunction

    // One clock: update the model at the edge, compare at the falling edge
    task automatic step();
        int f;
        @(posedge clk);
        if (!rst_n) begin
            m_en = 0; m_lat = 0; m_lane = 0; m_bank = 0;
        end else begin
            f = lowest_fail(rd_data, rd_par);
            if (m_en != 0 && rd_strobe && !rd_local && m_lat == 0 && f >= 0) begin
                m_lat = 1; m_lane = f; m_bank = rd_bank;
                capture_log.push_back(f);
            end
            if (en_wr) begin
                m_en = en_val;
                if (!en_val) begin m_lat = 0; m_lane = 0; m_bank = 0; end
            end
        end
        @(negedge clk);
        check(err_flag == (m_en != 0 && m_lat != 0), "R2 model flag", err_flag, (m_en != 0 && m_lat != 0));
        check(err_lane == (m_en != 0 ? m_lane : 0), "R3 model lane", err_lane, (m_en != 0 ? m_lane : 0));
        check(err_bank == (m_en != 0 ? m_bank : 0), "R3 model bank", err_bank, (m_en != 0 ? m_bank : 0));
        check(up_err == (route_up && m_en != 0 && m_lat != 0), "R11 model up", up_err,
              (route_up && m_en != 0 && m_lat != 0));
    endtask

    task automatic do_read(input bit bank, input bit local_acc, input logic [31:0] d, input logic [3:0] flip);
        rd_strobe = 1'b1; rd_local = local_acc; rd_bank = bank;
        rd_data = d; rd_par = good_par(d) ^ flip;
        step();
        rd_strobe = 1'b0; rd_local = 1'b0;
    endtask

    task automatic write_en(input bit v);
        en_wr = 1'b1; en_val = v;
        step();
        en_wr = 1'b0;
    endtask

    task automatic expect_status(input bit f, input int lane, input int bank, input string tag);
        check(err_flag == f, tag, err_flag, f);
        check(err_lane == lane, tag, err_lane, lane);
        check(err_bank == bank, tag, err_bank, bank);
    endtask

    initial begin
        rst_n = 1'b0; wr_data = '0; rd_strobe = 1'b0; rd_local = 1'b0; rd_bank = '0;
        rd_data = '0; rd_par = '0; en_wr = 1'b0; en_val = 1'b0; route_up = 1'b1;
        step(); step();
        // R12: reset state
        expect_status(1'b0, 0, 0, "R12 reset");
        check(up_err == 1'b0, "R12 reset up", up_err, 0);
        rst_n = 1'b1;
        step();

        // R1: write parity on several patterns
        begin
            logic [31:0] pats [5] = '{32'h0000_0000, 32'hFFFF_FFFF, 32'h0102_0408, 32'hA5C3_7E01, 32'h8000_0001};
            foreach (pats[k]) begin
                wr_data = pats[k];
                #1;
                check(wr_par == good_par(pats[k]), "R1 write parity", wr_par, good_par(pats[k]));
            end
        end

        write_en(1'b1);
        // R2: clean reads capture nothing
        do_read(1'b0, 1'b0, 32'hA5A5_0F0F, 4'b0000);
        do_read(1'b1, 1'b0, 32'h1234_5678, 4'b0000);
        check(err_flag == 1'b0, "R2 clean reads", err_flag, 0);

        // R10: bad bytes without strobe
        rd_strobe = 1'b0; rd_data = 32'h0000_00FF; rd_par = 4'b1111;
        step();
        check(err_flag == 1'b0, "R10 no strobe", err_flag, 0);

        // R2 and R3: lane 2 of bank 1 fails
        do_read(1'b1, 1'b0, 32'hDEAD_BEEF, 4'b0100);
        expect_status(1'b1, 2, 1, "R3 capture lane2 bank1");

        // R5: a later failure leaves the record unchanged
        do_read(1'b0, 1'b0, 32'h5555_AAAA, 4'b0001);
        expect_status(1'b1, 2, 1, "R5 sticky");

        // R7: enable written again while on keeps the record
        write_en(1'b1);
        expect_status(1'b1, 2, 1, "R7 re-enable keeps");

        // R11: routing control
        route_up = 1'b0;
        step();
        check(up_err == 1'b0, "R11 route off", up_err, 0);
        route_up = 1'b1;
        step();
        check(up_err == 1'b1, "R11 route on", up_err, 1);

        // R6: disable clears
        write_en(1'b0);
        expect_status(1'b0, 0, 0, "R6 disable clears");

        // R9: failing read while off is not captured
        do_read(1'b1, 1'b0, 32'h0F0F_F0F0, 4'b1000);
        expect_status(1'b0, 0, 0, "R9 off read");
        write_en(1'b1);
        check(err_flag == 1'b0, "R9 nothing held after re-enable", err_flag, 0);

        // R4: lanes 1 and 3 fail together
        do_read(1'b0, 1'b0, 32'h3C3C_3C3C, 4'b1010);
        expect_status(1'b1, 1, 0, "R4 lowest lane");

        // R7: disable then enable re-arms
        write_en(1'b0);
        write_en(1'b1);
        // R8: on-chip reads never checked
        do_read(1'b1, 1'b1, 32'h7777_7777, 4'b1111);
        check(err_flag == 1'b0, "R8 local read", err_flag, 0);
        do_read(1'b0, 1'b0, 32'hC001_D00D, 4'b1000);
        expect_status(1'b1, 3, 0, "R7 re-armed capture lane3");

        // R13: enable write and failing read in one cycle, checking off
        write_en(1'b0);
        en_wr = 1'b1; en_val = 1'b1;
        do_read(1'b1, 1'b0, 32'h0000_0001, 4'b0001);
        en_wr = 1'b0;
        check(err_flag == 1'b0, "R13 enable same cycle", err_flag, 0);
        // R13: disable write and failing read in one cycle, checking on
        en_wr = 1'b1; en_val = 1'b0;
        do_read(1'b1, 1'b0, 32'h0000_0100, 4'b0010);
        en_wr = 1'b0;
        write_en(1'b1);
        check(err_flag == 1'b0, "R13 disable same cycle", err_flag, 0);

        // R12: reset mid-run clears and turns checking off
        do_read(1'b1, 1'b0, 32'h0001_0000, 4'b0100);
        check(err_flag == 1'b1, "R12 pre-reset capture", err_flag, 1);
        rst_n = 1'b0;
        step();
        rst_n = 1'b1;
        expect_status(1'b0, 0, 0, "R12 reset clears");
        do_read(1'b0, 1'b0, 32'h0100_0000, 4'b1000);
        check(err_flag == 1'b0, "R12 off after reset", err_flag, 0);
        check(capture_log.size() == 5, "R2 capture count", capture_log.size(), 5);

        $display("test done: total=%0d bad=%0d", total, bad);
        finished = 1;
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule